// File: doc/BRIEF.md
# Stepped Trigger Sequencer

The sequencer walks a small program of up to four steps and decides, one clock at a time, what happens next. In every step it evaluates a set of prioritized conditions. Each condition tests a few external event flags and two internal comparator flags. The lowest-numbered true condition chooses an action word for that step. If no condition holds, the step's fallback action word is used instead. A single action word can do all of the following in the same cycle:
- pick the next step,
- fire the trigger output,
- raise the done flag,
- change an event counter,
- change an elapsed-cycle timer.

The timer and the counter are each compared, every cycle, against a threshold that belongs to the current step. The two results (greater than or equal) are offered back to the condition logic as terms. This lets a program wait for a number of events or cycles before it moves on. All configuration arrives on flat, static input vectors. A typical program arms the timer when a pattern is seen, waits until the timer passes a limit, fires the trigger, then stops and clears the timer and returns to step 0.

Top module: `step_trigger_seq`

## Requirements
- R1: While `rst_n` is low or `enable` is low, at every clock the state returns to idle. In idle the step is 0, the timer and counter are zero, the timer is stopped, and `trig_out` and `done_out` are low.
- R2: A condition word for NUM_SIG=4 is 13 bits wide, with these fields:
  - Signal i uses bits 2i+1 (include) and 2i (required level).
  - The timer flag uses bits 9 (include) and 8 (level).
  - The counter flag uses bits 11 (include) and 10 (level).
  - Bit 12 inverts the result.
  - The condition is true when every included term equals its required level, XORed with bit 12.
- R3: In the current step, the lowest-indexed true condition selects its action word. When no condition is true, the step's fallback word (slot NUM_CONDS) is applied.
- R4: Action bits [18:17] give the step that becomes current after the next clock edge.
- R5: Action bit 13 makes `trig_out` high for exactly the cycle after the one in which the action is applied.
- R6: Counter action bits:
  - Bit 9 increments the counter.
  - Bit 8 decrements it.
  - Bit 7 clears it, and clear beats both increment and decrement.
  - Increment and decrement together leave the count unchanged.
  - The count saturates at 0 and at 2^CNT_W-1.
  - `cnt_hit` is high when count >= the current step's counter threshold.
- R7: Timer action bits:
  - Bit 3 starts the timer and bit 2 stops it; stop beats start.
  - A running timer adds 1 per cycle, including the cycle in which it is started, and saturates at 2^TMR_W-1.
  - Bit 1 zeroes the timer for that cycle.
- R8: `tmr_hit` is high when timer >= the current step's timer threshold, evaluated every cycle.
- R9: Action bit 0 sets `done_out`. It stays high while `enable` stays high and clears only through R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run when high, hold idle when low |
| sig_in | input | NUM_SIG | External event flags |
| cfg_decode | input | 4*NUM_CONDS*(2*NUM_SIG+5) | Condition words; step s, condition c at slice (s*NUM_CONDS+c) |
| cfg_select | input | 4*(NUM_CONDS+1)*19 | Action words; step s, slot c at slice (s*(NUM_CONDS+1)+c); slot NUM_CONDS is the fallback |
| cfg_tmr_cmp | input | 4*TMR_W | Timer threshold for each step |
| cfg_cnt_cmp | input | 4*CNT_W | Counter threshold for each step |
| trig_out | output | 1 | One-cycle trigger pulse |
| done_out | output | 1 | Sticky completion flag |
| cur_step | output | 2 | Current step index |
| tmr_hit | output | 1 | Timer comparator flag |
| cnt_hit | output | 1 | Counter comparator flag |

## Verification
The hardest states to reach are the two saturation limits. Neither count is visible at the ports, and the timer limit needs 65535 running cycles before it saturates. The stimulus sets a fallback word that keeps the block in one step and only increments, or only runs the timer. It then places the threshold at the maximum value and watches the comparator flag stay high after the limit. A wrapping design would drop the flag back to low. Priority and fallback selection are exercised by conditions with no included terms, which are always true (or always false when inverted). Long stretches with random programs, thresholds and event flags are then compared cycle by cycle against a behavioural model.

// File: rtl/tsq_pkg.sv
`timescale 1ns/1ps
package tsq_pkg;
  localparam int NEXT_W    = 2;
  localparam int NUM_STEPS = 1 << NEXT_W;
  localparam int SEL_W     = 19;

  typedef struct packed {
    logic [NEXT_W-1:0] next;
    logic              trig;
    logic              cnt_inc;
    logic              cnt_dec;
    logic              cnt_clr;
    logic              tmr_run;
    logic              tmr_pause;
    logic              tmr_clr;
    logic              done;
  } action_t;

  // Field positions of an action word are fixed; the step jump sits at the top.
  function automatic action_t sel_to_action(input logic [SEL_W-1:0] w);
    action_t a;
    logic    unused_bits;
    unused_bits = ^{w[16:14], w[12:10], w[6:4]};
    a.next      = w[18:17];
    a.trig      = w[13];
    a.cnt_inc   = w[9];
    a.cnt_dec   = w[8];
    a.cnt_clr   = w[7];
    a.tmr_run   = w[3];
    a.tmr_pause = w[2];
    a.tmr_clr   = w[1];
    a.done      = w[0];
    return a;
  endfunction
endpackage

// File: rtl/tsq_cond_decode.sv
`timescale 1ns/1ps
module tsq_cond_decode #(
  parameter int NUM_SIG   = 4,
  parameter int NUM_CONDS = 4,
  parameter int DEC_W     = 2*NUM_SIG+5
) (
  input  logic [NUM_CONDS*DEC_W-1:0] dec_words,
  input  logic [NUM_SIG-1:0]         sig,
  input  logic                       tmr_hit,
  input  logic                       cnt_hit,
  output logic [NUM_CONDS-1:0]       cond_true
);
  localparam int NT = NUM_SIG + 2;

  logic [NT-1:0] terms;
  assign terms = {cnt_hit, tmr_hit, sig};

  for (genvar c = 0; c < NUM_CONDS; c++) begin : g_cond
    logic [DEC_W-1:0] w;
    logic [NT-1:0]    miss;
    assign w = dec_words[c*DEC_W +: DEC_W];
    for (genvar t = 0; t < NT; t++) begin : g_term
      // included term whose level differs from the required one
      assign miss[t] = w[2*t+1] & (terms[t] ^ w[2*t]);
    end
    assign cond_true[c] = (~|miss) ^ w[DEC_W-1];
  end
endmodule

// File: rtl/tsq_pick.sv
`timescale 1ns/1ps
module tsq_pick import tsq_pkg::*; #(
  parameter int NUM_CONDS = 4
) (
  input  logic [NUM_CONDS-1:0]           cond_true,
  input  logic [(NUM_CONDS+1)*SEL_W-1:0] sel_words,
  output logic [NUM_CONDS-1:0]           grant,
  output logic                           any_hit,
  output logic [SEL_W-1:0]               sel_word
);
  always_comb begin
    grant    = '0;
    any_hit  = 1'b0;
    sel_word = sel_words[NUM_CONDS*SEL_W +: SEL_W];
    for (int c = NUM_CONDS-1; c >= 0; c--) begin
      if (cond_true[c]) begin
        grant    = '0;
        grant[c] = 1'b1;
        any_hit  = 1'b1;
        sel_word = sel_words[c*SEL_W +: SEL_W];
      end
    end
  end
endmodule

// File: rtl/tsq_timer.sv
`timescale 1ns/1ps
module tsq_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         run_set,
  input  logic         pause,
  input  logic         clr,
  input  logic [W-1:0] cmp,
  output logic [W-1:0] val,
  output logic         hit
);
  function automatic logic [W-1:0] bump_up(input logic [W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  logic         run_q, run_d;
  logic [W-1:0] val_q, val_d;

  always_comb begin
    run_d = pause ? 1'b0 : (run_set ? 1'b1 : run_q);
    if (clr)        val_d = '0;
    else if (run_d) val_d = bump_up(val_q);
    else            val_d = val_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      val_q <= '0;
    end else if (!enable) begin
      run_q <= 1'b0;
      val_q <= '0;
    end else begin
      run_q <= run_d;
      val_q <= val_d;
    end
  end

  assign val = val_q;
  assign hit = (val_q >= cmp);
endmodule

// File: rtl/tsq_counter.sv
`timescale 1ns/1ps
module tsq_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         inc,
  input  logic         dec,
  input  logic         clr,
  input  logic [W-1:0] cmp,
  output logic [W-1:0] val,
  output logic         hit
);
  function automatic logic [W-1:0] step_up(input logic [W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  function automatic logic [W-1:0] step_down(input logic [W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  logic [W-1:0] val_q, val_d;

  always_comb begin
    if (clr)              val_d = '0;
    else if (inc && !dec) val_d = step_up(val_q);
    else if (dec && !inc) val_d = step_down(val_q);
    else                  val_d = val_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       val_q <= '0;
    else if (!enable) val_q <= '0;
    else              val_q <= val_d;
  end

  assign val = val_q;
  assign hit = (val_q >= cmp);
endmodule

// File: rtl/step_trigger_seq.sv
`timescale 1ns/1ps
module step_trigger_seq import tsq_pkg::*; #(
  parameter int NUM_SIG   = 4,
  parameter int NUM_CONDS = 4,
  parameter int TMR_W     = 16,
  parameter int CNT_W     = 8
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        enable,
  input  logic [NUM_SIG-1:0]                          sig_in,
  input  logic [NUM_STEPS*NUM_CONDS*(2*NUM_SIG+5)-1:0] cfg_decode,
  input  logic [NUM_STEPS*(NUM_CONDS+1)*SEL_W-1:0]    cfg_select,
  input  logic [NUM_STEPS*TMR_W-1:0]                  cfg_tmr_cmp,
  input  logic [NUM_STEPS*CNT_W-1:0]                  cfg_cnt_cmp,
  output logic                                        trig_out,
  output logic                                        done_out,
  output logic [NEXT_W-1:0]                           cur_step,
  output logic                                        tmr_hit,
  output logic                                        cnt_hit
);
  localparam int DEC_W    = 2*NUM_SIG + 5;
  localparam int DEC_SPAN = NUM_CONDS * DEC_W;
  localparam int SEL_SPAN = (NUM_CONDS + 1) * SEL_W;

  logic [NEXT_W-1:0]    step_q;
  logic                 trig_q, done_q;

  // per-step configuration slices
  logic [DEC_SPAN-1:0]  step_dec;
  logic [SEL_SPAN-1:0]  step_sel;
  logic [TMR_W-1:0]     step_tcmp;
  logic [CNT_W-1:0]     step_ccmp;

  assign step_dec  = cfg_decode[int'(step_q)*DEC_SPAN +: DEC_SPAN];
  assign step_sel  = cfg_select[int'(step_q)*SEL_SPAN +: SEL_SPAN];
  assign step_tcmp = cfg_tmr_cmp[int'(step_q)*TMR_W +: TMR_W];
  assign step_ccmp = cfg_cnt_cmp[int'(step_q)*CNT_W +: CNT_W];

  // named internal events
  logic [NUM_CONDS-1:0] cond_true;
  logic [NUM_CONDS-1:0] grant;
  logic                 any_hit;
  logic [SEL_W-1:0]     sel_word;
  action_t              act;
  logic [NEXT_W-1:0]    act_next;
  logic                 act_trig, act_done;
  logic                 act_cnt_inc, act_cnt_dec, act_cnt_clr;
  logic                 act_tmr_run, act_tmr_pause, act_tmr_clr;
  logic [TMR_W-1:0]     tmr_val;
  logic [CNT_W-1:0]     cnt_val;
  logic                 tmr_cmp_hit, cnt_cmp_hit;

  tsq_cond_decode #(
    .NUM_SIG   (NUM_SIG),
    .NUM_CONDS (NUM_CONDS),
    .DEC_W     (DEC_W)
  ) u_decode (
    .dec_words (step_dec),
    .sig       (sig_in),
    .tmr_hit   (tmr_cmp_hit),
    .cnt_hit   (cnt_cmp_hit),
    .cond_true (cond_true)
  );

  tsq_pick #(
    .NUM_CONDS (NUM_CONDS)
  ) u_pick (
    .cond_true (cond_true),
    .sel_words (step_sel),
    .grant     (grant),
    .any_hit   (any_hit),
    .sel_word  (sel_word)
  );

  assign act           = sel_to_action(sel_word);
  assign act_next      = act.next;
  assign act_trig      = act.trig;
  assign act_done      = act.done;
  assign act_cnt_inc   = act.cnt_inc;
  assign act_cnt_dec   = act.cnt_dec;
  assign act_cnt_clr   = act.cnt_clr;
  assign act_tmr_run   = act.tmr_run;
  assign act_tmr_pause = act.tmr_pause;
  assign act_tmr_clr   = act.tmr_clr;

  tsq_timer #(
    .W (TMR_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .run_set (act_tmr_run),
    .pause   (act_tmr_pause),
    .clr     (act_tmr_clr),
    .cmp     (step_tcmp),
    .val     (tmr_val),
    .hit     (tmr_cmp_hit)
  );

  tsq_counter #(
    .W (CNT_W)
  ) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .inc    (act_cnt_inc),
    .dec    (act_cnt_dec),
    .clr    (act_cnt_clr),
    .cmp    (step_ccmp),
    .val    (cnt_val),
    .hit    (cnt_cmp_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      trig_q <= 1'b0;
      done_q <= 1'b0;
    end else if (!enable) begin
      step_q <= '0;
      trig_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      step_q <= act_next;
      trig_q <= act_trig;
      done_q <= done_q | act_done;
    end
  end

  assign trig_out = trig_q;
  assign done_out = done_q;
  assign cur_step = step_q;
  assign tmr_hit  = tmr_cmp_hit;
  assign cnt_hit  = cnt_cmp_hit;
endmodule

// File: rtl/step_trigger_seq_chk.sv
`timescale 1ns/1ps
module step_trigger_seq_chk #(
  parameter int NUM_CONDS = 4,
  parameter int TMR_W     = 16,
  parameter int CNT_W     = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 enable,
  input logic                 trig_out,
  input logic                 done_out,
  input logic [1:0]           cur_step,
  input logic [NUM_CONDS-1:0] grant,
  input logic [1:0]           act_next,
  input logic                 act_trig,
  input logic                 act_cnt_clr,
  input logic                 act_tmr_pause,
  input logic                 act_tmr_clr,
  input logic [TMR_W-1:0]     tmr_val,
  input logic [CNT_W-1:0]     cnt_val
);
  a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cur_step == 2'd0 && !trig_out && !done_out && tmr_val == '0 && cnt_val == '0));

  a_r3_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r4_step_follows: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> cur_step == $past(act_next));

  a_r5_trig_follows: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> trig_out == $past(act_trig));

  a_r6_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && act_cnt_clr) |=> cnt_val == '0);

  a_r7_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && act_tmr_pause && !act_tmr_clr) |=> $stable(tmr_val));

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && done_out) |=> done_out);
endmodule

bind step_trigger_seq step_trigger_seq_chk #(
  .NUM_CONDS (NUM_CONDS),
  .TMR_W     (TMR_W),
  .CNT_W     (CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .enable        (enable),
  .trig_out      (trig_out),
  .done_out      (done_out),
  .cur_step      (cur_step),
  .grant         (grant),
  .act_next      (act_next),
  .act_trig      (act_trig),
  .act_cnt_clr   (act_cnt_clr),
  .act_tmr_pause (act_tmr_pause),
  .act_tmr_clr   (act_tmr_clr),
  .tmr_val       (tmr_val),
  .cnt_val       (cnt_val)
);

// File: tb/step_trigger_seq_bench.sv
`timescale 1ns/1ps
module step_trigger_seq_bench;
  localparam int NS = 4, NC = 4, NSIG = 4, TW = 16, CW = 8;
  localparam int DW = 2*NSIG + 5, SW = 19;
  localparam int TMAX = (1 << TW) - 1, CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [NSIG-1:0] sig = '0;
  logic [DW-1:0] dcfg [NS][NC];
  logic [SW-1:0] scfg [NS][NC+1];
  logic [TW-1:0] tcmp [NS];
  logic [CW-1:0] ccmp [NS];
  logic [NS*NC*DW-1:0]     f_dec;
  logic [NS*(NC+1)*SW-1:0] f_sel;
  logic [NS*TW-1:0]        f_tc;
  logic [NS*CW-1:0]        f_cc;
  logic trig_out, done_out, tmr_hit, cnt_hit;
  logic [1:0] cur_step;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      for (int c = 0; c < NC; c++) f_dec[(s*NC+c)*DW +: DW] = dcfg[s][c];
      for (int c = 0; c <= NC; c++) f_sel[(s*(NC+1)+c)*SW +: SW] = scfg[s][c];
      f_tc[s*TW +: TW] = tcmp[s];
      f_cc[s*CW +: CW] = ccmp[s];
    end
  end

  step_trigger_seq u_step_trigger_seq (
    .clk(clk), .rst_n(rst_n), .enable(en), .sig_in(sig),
    .cfg_decode(f_dec), .cfg_select(f_sel), .cfg_tmr_cmp(f_tc), .cfg_cnt_cmp(f_cc),
    .trig_out(trig_out), .done_out(done_out), .cur_step(cur_step),
    .tmr_hit(tmr_hit), .cnt_hit(cnt_hit)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference state
  int m_step = 0, m_tmr = 0, m_cnt = 0;
  bit m_run = 0, m_trig = 0, m_done = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [SW-1:0] act_word(int nxt, int bits);
    return SW'((nxt << 17) | bits);
  endfunction

  function automatic bit cond_ok(int s, int c, bit th, bit ch);
    logic [DW-1:0] w;
    bit ok;
    w = dcfg[s][c];
    ok = 1'b1;
    for (int i = 0; i < NSIG; i++)
      if (w[2*i+1] && (sig[i] != w[2*i])) ok = 1'b0;
    if (w[2*NSIG+1] && (th != w[2*NSIG])) ok = 1'b0;
    if (w[2*NSIG+3] && (ch != w[2*NSIG+2])) ok = 1'b0;
    if (w[2*NSIG+4]) ok = !ok;
    return ok;
  endfunction

  task automatic compare();
    bit th, ch;
    th = (m_tmr >= int'(tcmp[m_step]));
    ch = (m_cnt >= int'(ccmp[m_step]));
    chk(int'(cur_step) == m_step, "R4 step", int'(cur_step), m_step);
    chk(trig_out == m_trig, "R5 trigger", int'(trig_out), int'(m_trig));
    chk(done_out == m_done, "R9 done", int'(done_out), int'(m_done));
    chk(tmr_hit == th, "R7/R8 timer flag", int'(tmr_hit), int'(th));
    chk(cnt_hit == ch, "R6 counter flag", int'(cnt_hit), int'(ch));
  endtask

  task automatic tick();
    int n_step, n_tmr, n_cnt, pick;
    bit n_run, n_trig, n_done, th, ch;
    logic [SW-1:0] w;
    if (!rst_n || !en) begin
      n_step = 0; n_tmr = 0; n_cnt = 0; n_run = 0; n_trig = 0; n_done = 0;
    end else begin
      th = (m_tmr >= int'(tcmp[m_step]));
      ch = (m_cnt >= int'(ccmp[m_step]));
      pick = NC;
      for (int c = NC-1; c >= 0; c--) if (cond_ok(m_step, c, th, ch)) pick = c;
      w = scfg[m_step][pick];
      n_step = int'(w[18:17]);
      n_trig = w[13];
      n_done = m_done | w[0];
      if (w[7]) n_cnt = 0;
      else if (w[9] && !w[8]) n_cnt = (m_cnt == CMAX) ? m_cnt : m_cnt + 1;
      else if (w[8] && !w[9]) n_cnt = (m_cnt == 0) ? 0 : m_cnt - 1;
      else n_cnt = m_cnt;
      n_run = w[2] ? 1'b0 : (w[3] ? 1'b1 : m_run);
      if (w[1]) n_tmr = 0;
      else if (n_run) n_tmr = (m_tmr == TMAX) ? m_tmr : m_tmr + 1;
      else n_tmr = m_tmr;
    end
    @(posedge clk);
    m_step = n_step; m_tmr = n_tmr; m_cnt = n_cnt;
    m_run = n_run; m_trig = n_trig; m_done = n_done;
    @(negedge clk);
    compare();
  endtask

  task automatic clear_cfg();
    for (int s = 0; s < NS; s++) begin
      for (int c = 0; c < NC; c++) dcfg[s][c] = DW'(1) << (DW-1); // always false
      for (int c = 0; c < NC; c++) scfg[s][c] = act_word(s, 0);
      scfg[s][NC] = act_word(s, 0);
      tcmp[s] = '1;
      ccmp[s] = '1;
    end
  endtask

  task automatic run_ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    clear_cfg();
    @(negedge clk);
    run_ticks(2);
    chk(cur_step == 2'd0 && !trig_out && !done_out, "R1 reset idle", int'(cur_step), 0);
    rst_n = 1'b1;
    run_ticks(2);
    chk(cur_step == 2'd0 && !trig_out, "R1 disabled idle", int'(cur_step), 0);

    // pattern / arm timer / fire example
    dcfg[0][0] = 13'b0_00_00_11_10_11_10;  // sig == 4'b1010
    dcfg[0][1] = 13'b0_00_00_11_10_11_11;  // sig == 4'b1011
    scfg[0][0] = act_word(1, 'h8);
    scfg[0][1] = act_word(1, 'h8);
    scfg[0][NC] = act_word(0, 0);
    dcfg[1][0] = 13'b0_00_11_00_00_00_00;  // timer flag high
    scfg[1][0] = act_word(0, 'h2006);
    scfg[1][NC] = act_word(1, 0);
    tcmp[1] = 16'd3;
    en = 1'b1;
    tick();
    sig = 4'h2;
    tick();
    chk(cur_step == 2'd0, "R2 partial pattern ignored", int'(cur_step), 0);
    sig = 4'hA;
    tick();
    chk(cur_step == 2'd1, "R2 R4 pattern jumps", int'(cur_step), 1);
    sig = 4'h0;
    tick(); chk(!trig_out, "R8 below threshold", int'(trig_out), 0);
    tick(); chk(!trig_out, "R8 below threshold", int'(trig_out), 0);
    tick();
    chk(trig_out == 1'b1, "R5 R7 trigger at count 3", int'(trig_out), 1);
    chk(cur_step == 2'd0, "R4 return to step 0", int'(cur_step), 0);
    tick();
    chk(trig_out == 1'b0, "R5 single pulse", int'(trig_out), 0);
    sig = 4'hB;
    tick();
    chk(cur_step == 2'd1, "R2 second pattern", int'(cur_step), 1);
    sig = 4'h0;

    // priority and fallback
    en = 1'b0; tick(); clear_cfg(); en = 1'b1;
    dcfg[0][0] = '0; scfg[0][0] = act_word(2, 0);
    dcfg[0][1] = '0; scfg[0][1] = act_word(3, 0);
    scfg[2][NC] = act_word(1, 'h1);
    tick();
    chk(cur_step == 2'd2, "R3 lowest index wins", int'(cur_step), 2);
    tick();
    chk(cur_step == 2'd1, "R3 fallback word", int'(cur_step), 1);
    chk(done_out == 1'b1, "R9 done set", int'(done_out), 1);
    run_ticks(3);
    chk(done_out == 1'b1, "R9 done sticky", int'(done_out), 1);
    en = 1'b0; tick();
    chk(done_out == 1'b0, "R1 R9 done cleared", int'(done_out), 0);

    // counter saturation and clear priority
    clear_cfg(); en = 1'b1;
    scfg[0][NC] = act_word(0, 'h200);
    ccmp[0] = 8'hFF;
    run_ticks(300);
    chk(cnt_hit == 1'b1, "R6 counter saturates high", int'(cnt_hit), 1);
    scfg[0][NC] = act_word(0, 'h300);
    tick();
    chk(cnt_hit == 1'b1, "R6 inc and dec cancel", int'(cnt_hit), 1);
    scfg[0][NC] = act_word(0, 'h280);
    ccmp[0] = 8'd1;
    tick();
    chk(cnt_hit == 1'b0, "R6 clear beats increment", int'(cnt_hit), 0);
    scfg[0][NC] = act_word(0, 'h100);
    ccmp[0] = 8'd0;
    run_ticks(3);
    chk(cnt_hit == 1'b1, "R6 floor at zero", int'(cnt_hit), 1);

    // timer saturation and pause priority
    scfg[0][NC] = act_word(0, 'h8);
    tcmp[0] = 16'hFFFF;
    run_ticks(66000);
    chk(tmr_hit == 1'b1, "R7 timer saturates", int'(tmr_hit), 1);
    scfg[0][NC] = act_word(0, 'hC);
    tick();
    scfg[0][NC] = act_word(0, 'h2);
    tcmp[0] = 16'd1;
    tick();
    scfg[0][NC] = act_word(0, 0);
    run_ticks(4);
    chk(tmr_hit == 1'b0, "R7 pause beats run", int'(tmr_hit), 0);

    // random programs
    for (int blk = 0; blk < 20; blk++) begin
      en = 1'b0; tick(); en = 1'b1;
      for (int s = 0; s < NS; s++) begin
        for (int c = 0; c < NC; c++)
          dcfg[s][c] = DW'($urandom & $urandom & $urandom) | (DW'($urandom % 4 == 0) << (DW-1));
        for (int c = 0; c <= NC; c++) scfg[s][c] = SW'($urandom);
        tcmp[s] = TW'($urandom % 8);
        ccmp[s] = CW'($urandom % 6);
      end
      for (int i = 0; i < 150; i++) begin
        sig = NSIG'($urandom);
        tick();
      end
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule